// File: doc/BRIEF.md
# Set/Clear Peripheral Reset and Clock-Stop Register Block

This block holds two 64-bit control vectors for a chip's peripherals: one vector of reset lines and one vector of clock-stop bits. Each vector is stored as a lower and an upper 32-bit word. Every word has two write addresses. A write to its base address turns on every bit given as 1. A write four bytes higher turns off every bit given as 1. Bits given as 0 stay as they were. Software can therefore change a single peripheral's reset or clock bit with one store and no read-modify-write.

The reset vector drives the per-peripheral reset outputs straight from the register. The clock-stop vector is turned into per-peripheral clock-enable outputs through one register stage. A 1 in a clock-stop bit means that peripheral's clock is off, except at one bit position (14 by default), where a 1 means the clock runs. The bus is a simple single-cycle register port with address, write strobe, write data and combinational read data.

Top module: `rstclk_ctl`

## Requirements
- R1: During and right after reset, every reset bit reads 1, every clock-stop bit reads 1 except the inverted bit (14), which reads 0. All reset outputs are 1 and all clock-enable outputs are 0.
- R2: A write to a base address (reset words 0x040 and 0x050, clock words 0x080 and 0x090) sets each bit of that word whose write-data bit is 1 and leaves the others unchanged.
- R3: A write to base+0x04 (0x044, 0x054, 0x084, 0x094) clears each bit of that word whose write-data bit is 1 and leaves the others unchanged.
- R4: Global index i (0 to 63) lives in the lower word when i < 32 and in the upper word (0x050 or 0x090) when i >= 32, at bit position i mod 32. periph_rst[i] and periph_clk_en[i] follow that bit.
- R5: A read of either the base address or base+0x04 returns the word's current value in the same cycle. A read of any other address returns 0.
- R6: periph_clk_en[i] is the inverse of clock-stop bit i for every i except the inverted bit (14), where it equals the clock-stop bit.
- R7: periph_rst changes on the clock edge that takes the write. periph_clk_en changes one edge later.
- R8: A write to an address outside the eight mapped addresses changes no bit.
- R9: While bus_wr is 0, no bit changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data; 1 bits select the bits to set or clear |
| bus_rdata | output | 32 | Current value of the addressed word, 0 if unmapped |
| periph_rst | output | 64 | Reset line per peripheral, 1 = held in reset |
| periph_clk_en | output | 64 | Registered clock enable per peripheral, 1 = running |

## Verification
The bench aims at the places where a set/clear map usually breaks: the clear alias of each word, the split of indices across the lower and upper words, and the one bit of opposite polarity. A design that wrote data straight into the word instead of OR-ing or masking it would lose untouched bits. One that swapped the banks would move a bit to the wrong half of the outputs. One that treated bit 14 like the others would start that clock running out of reset. Further checks cover the one-edge lag of the clock enables against the reset outputs, writes to unmapped neighbours such as 0x048 and 0x04C, and an idle cycle with live address and data. A design that fell short on any of these would either change a bit it must not touch or change the enables a cycle early.

// File: rtl/rstclk_pkg.sv
package rstclk_pkg;
    localparam int ADDR_W   = 12;
    localparam int WORD_W   = 32;
    localparam int NUM_WORDS = 4;   // reset lo, reset hi, clock lo, clock hi
    localparam int CLR_OFS  = 4;    // clear alias sits this far above the base

    localparam logic [ADDR_W-1:0] RST_LO_BASE = 12'h040;
    localparam logic [ADDR_W-1:0] RST_HI_BASE = 12'h050;
    localparam logic [ADDR_W-1:0] CLK_LO_BASE = 12'h080;
    localparam logic [ADDR_W-1:0] CLK_HI_BASE = 12'h090;

    // word slot numbering used by decode and storage
    typedef enum logic [1:0] {
        SLOT_RST_LO = 2'd0,
        SLOT_RST_HI = 2'd1,
        SLOT_CLK_LO = 2'd2,
        SLOT_CLK_HI = 2'd3
    } slot_e;
endpackage

// File: rtl/rstclk_decode.sv
module rstclk_decode #(
    parameter int ADDR_W = 12,
    parameter int NWORDS = 4,
    parameter int CLR_OFS = 4,
    parameter logic [NWORDS*ADDR_W-1:0] BASES = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic [NWORDS-1:0] set_stb,
    output logic [NWORDS-1:0] clr_stb,
    output logic [NWORDS-1:0] rd_hit
);
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        localparam logic [ADDR_W-1:0] BASE_A = BASES[w*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] CLR_A  = BASE_A + ADDR_W'(CLR_OFS);
        logic at_base;
        logic at_clr;
        assign at_base    = (addr == BASE_A);
        assign at_clr     = (addr == CLR_A);
        assign set_stb[w] = wr & at_base;
        assign clr_stb[w] = wr & at_clr;
        assign rd_hit[w]  = at_base | at_clr;
    end
endmodule

// File: rtl/rstclk_bank.sv
module rstclk_bank #(
    parameter int WIDTH = 32,
    parameter logic [WIDTH-1:0] INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] word
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_stb) st_d.bits = st_q.bits | wdata;
        if (clr_stb) st_d.bits = st_q.bits & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bits: INIT};
        else        st_q <= st_d;
    end

    assign word = st_q.bits;

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((word & $past(wdata)) == $past(wdata)));
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((word & $past(wdata)) == '0));
    assert_untouched_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb || clr_stb) |=> ((word & ~$past(wdata)) == ($past(word) & ~$past(wdata))));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(word));
endmodule

// File: rtl/rstclk_enmap.sv
module rstclk_enmap #(
    parameter int N = 64,
    parameter logic [N-1:0] INV_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] stop_vec,
    output logic [N-1:0] clk_en
);
    typedef struct packed {
        logic [N-1:0] en;
    } en_state_t;

    en_state_t   st_d, st_q;
    logic [N-1:0] en_comb;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (INV_MASK[i]) begin : g_inv
            assign en_comb[i] = stop_vec[i];
        end else begin : g_norm
            assign en_comb[i] = ~stop_vec[i];
        end
    end

    always_comb begin
        st_d    = st_q;
        st_d.en = en_comb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{en: '0};
        else        st_q <= st_d;
    end

    assign clk_en = st_q.en;
endmodule

// File: rtl/rstclk_ctl.sv
module rstclk_ctl
    import rstclk_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int WW      = WORD_W,
    parameter int INV_BIT = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [11:0]   bus_addr,
    input  logic          bus_wr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic [63:0]   periph_rst,
    output logic [63:0]   periph_clk_en
);
    localparam int NW       = NUM_WORDS;
    localparam int VEC_W    = 2 * WW;
    localparam int NORM_BIT = (INV_BIT == 0) ? 1 : 0;
    localparam logic [VEC_W-1:0] INV_MASK = VEC_W'(1) << INV_BIT;
    localparam logic [VEC_W-1:0] STOP_INIT = ~INV_MASK;
    localparam logic [VEC_W-1:0] RST_INIT  = '1;
    localparam logic [NW*AW-1:0] BASES = {AW'(CLK_HI_BASE), AW'(CLK_LO_BASE),
                                          AW'(RST_HI_BASE), AW'(RST_LO_BASE)};
    localparam logic [NW*WW-1:0] INITS = {STOP_INIT, RST_INIT};

    logic [NW-1:0]  set_stb, clr_stb, rd_hit;
    logic [WW-1:0]  words [NW];
    logic [VEC_W-1:0] stop_vec;

    rstclk_decode #(
        .ADDR_W(AW), .NWORDS(NW), .CLR_OFS(CLR_OFS), .BASES(BASES)
    ) u_decode (
        .addr(bus_addr), .wr(bus_wr),
        .set_stb(set_stb), .clr_stb(clr_stb), .rd_hit(rd_hit)
    );

    for (genvar w = 0; w < NW; w++) begin : g_bank
        rstclk_bank #(
            .WIDTH(WW), .INIT(INITS[w*WW +: WW])
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .set_stb(set_stb[w]), .clr_stb(clr_stb[w]),
            .wdata(bus_wdata), .word(words[w])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NW; w++) begin
            if (rd_hit[w]) bus_rdata = bus_rdata | words[w];
        end
    end

    assign periph_rst = {words[SLOT_RST_HI], words[SLOT_RST_LO]};
    assign stop_vec   = {words[SLOT_CLK_HI], words[SLOT_CLK_LO]};

    rstclk_enmap #(
        .N(VEC_W), .INV_MASK(INV_MASK)
    ) u_enmap (
        .clk(clk), .rst_n(rst_n),
        .stop_vec(stop_vec), .clk_en(periph_clk_en)
    );

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(periph_rst) && $stable(stop_vec)));
    assert_inv_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (periph_clk_en[INV_BIT] == $past(stop_vec[INV_BIT])));
    assert_norm_pol_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (periph_clk_en[NORM_BIT] == !$past(stop_vec[NORM_BIT])));
    assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_stb, clr_stb}));
endmodule

// File: tb/rstclk_ctl_bench.sv
module rstclk_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] periph_rst;
    logic [63:0] periph_clk_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 4 ns period

    rstclk_ctl u_rstclk_ctl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .periph_rst(periph_rst), .periph_clk_en(periph_clk_en)
    );

    // {write addr, write data, read addr, expected read}
    localparam int NVEC = 10;
    localparam logic [87:0] VEC [NVEC] = '{
        {12'h044, 32'h0000_00F0, 12'h040, 32'hFFFF_FF0F},  // R3 clear lo reset
        {12'h040, 32'h0000_0030, 12'h044, 32'hFFFF_FF3F},  // R2 set, R5 alias read
        {12'h054, 32'hFFFF_0000, 12'h050, 32'h0000_FFFF},  // R4 upper reset word
        {12'h050, 32'h8000_0000, 12'h054, 32'h8000_FFFF},  // R2 set index 63
        {12'h084, 32'h0000_000F, 12'h080, 32'hFFFF_BFF0},  // R3 clock clear
        {12'h080, 32'h0000_4000, 12'h084, 32'hFFFF_FFF0},  // R2 clock set bit 14
        {12'h094, 32'h0000_0001, 12'h090, 32'hFFFF_FFFE},  // R4 clock index 32
        {12'h0A0, 32'hFFFF_FFFF, 12'h0A0, 32'h0000_0000},  // R5 unmapped read
        {12'h048, 32'h0000_0000, 12'h040, 32'hFFFF_FF3F},  // R8 unmapped write
        {12'h04C, 32'hFFFF_FFFF, 12'h040, 32'hFFFF_FF3F}   // R8 unmapped write
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_word(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_word(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_wr = 1'b0;
        #1;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        // R1: state while held in reset
        repeat (3) @(negedge clk);
        check("R1 rst out", periph_rst, {64{1'b1}});
        check("R1 clk en", periph_clk_en, 64'h0);
        rd_word(12'h080, r); check("R1 clk lo", {32'h0, r}, {32'h0, 32'hFFFF_BFFF});
        rd_word(12'h090, r); check("R1 clk hi", {32'h0, r}, {32'h0, 32'hFFFF_FFFF});
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R1 en after release", periph_clk_en, 64'h0);
        rd_word(12'h050, r); check("R1 rst hi", {32'h0, r}, {32'h0, 32'hFFFF_FFFF});

        for (int k = 0; k < NVEC; k++) begin
            wr_word(VEC[k][87:76], VEC[k][75:44]);
            rd_word(VEC[k][43:32], r);
            check($sformatf("R2/R3/R4/R5/R8 vector %0d", k), {32'h0, r}, {32'h0, VEC[k][31:0]});
        end

        // R4, R6: outputs after the table
        @(negedge clk);
        check("R4 rst out", periph_rst, 64'h8000_FFFF_FFFF_FF3F);
        check("R6 clk en", periph_clk_en, 64'h0000_0001_0000_400F);

        // R9: strobe low with live address and data
        @(negedge clk);
        bus_addr = 12'h044; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b0;
        @(negedge clk); @(negedge clk);
        rd_word(12'h040, r); check("R9 idle", {32'h0, r}, {32'h0, 32'hFFFF_FF3F});
        check("R9 rst out", periph_rst, 64'h8000_FFFF_FFFF_FF3F);

        // R7: reset output on the write edge, clock enable one edge later
        wr_word(12'h044, 32'h0000_0001);
        check("R7 rst same edge", {63'h0, periph_rst[0]}, 64'h0);
        wr_word(12'h084, 32'h0000_0020);
        check("R7 en before", {63'h0, periph_clk_en[5]}, 64'h0);
        @(negedge clk);
        check("R7 en after", {63'h0, periph_clk_en[5]}, 64'h1);

        // R6: inverted bit stops when cleared
        wr_word(12'h084, 32'h0000_4000);
        check("R6 inv before", {63'h0, periph_clk_en[14]}, 64'h1);
        @(negedge clk);
        check("R6 inv after", {63'h0, periph_clk_en[14]}, 64'h0);
        check("R6 clk en", periph_clk_en, 64'h0000_0001_0000_002F);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule